// File: doc/BRIEF.md
# Shadow-Address Special-Operation Launcher

This block sits on a host bus and prepares multi-word remote operations: fetch-and-store, fetch-and-increment, compare-and-swap and a non-blocking remote-to-local copy. Software fills a per-process argument context with ordinary uncached stores. Physical-address arguments are handed over through a shadow alias of the address space. A store whose top address bit is set does not act as a memory write. Its low address bits become the argument, and its data word names the target context and carries a key. The argument is accepted only when that key matches the key that privileged software gave the context.

A context keeps its contents, for any length of time, until the host reads that context's launch register. The read checks that every field the opcode needs has been supplied. If so, it emits a one-cycle request to the packet engine and clears the context's field-valid flags. A copy returns at once. An atomic stalls the read until the remote old value comes back, and the read then returns that value. Ordinary remote stores pass through to a forwarding port.

Top module: `shadow_op_launcher`

## Requirements
- R1: A store with bus_addr[31]=1 and a matching key writes bus_addr[30:0] into context bus_wdata[31:29]. It goes to the remote-address slot when bus_wdata[16]=0 and to the local-address slot when bus_wdata[16]=1, and it sets that slot's valid flag. The key is bus_wdata[15:0].
- R2: A shadow store whose key differs from the context's key leaves every field and flag of that context unchanged.
- R3: Window accesses use bus_addr[31:30]=01, context index bus_addr[7:5] and field bus_addr[4:2]. Reads return field 0 as the remote address, 1 as the local address, 2 as operand A, 3 as operand B, 4 as the opcode and 5 as the status. Writes to fields 2, 3 and 4 store the data and set the valid flag. Writes to fields 0, 1, 5 and 7 are ignored.
- R4: Status is {err at bit 5, valid flags [4:0] = opcode, operand B, operand A, local address, remote address}. Opcode encoding: 0 fetch-and-store, 1 fetch-and-increment, 2 compare-and-swap, 3 copy.
- R5: With no access to a context, the context's contents stay unchanged for any number of cycles.
- R6: A read of field 7 rejects the launch when a required field is not valid. Every opcode needs the remote address and the opcode. Fetch-and-store also needs operand A, compare-and-swap needs both operands, and copy needs the local address. A rejected launch returns 0xFFFFFFFF without waiting, issues no request, sets err and keeps the flags.
- R7: An accepted launch drives req_valid for one cycle, in the cycle after acceptance, carrying the context index, opcode and fields. It also clears the context's valid flags and err.
- R8: An accepted copy launch returns 0 with no wait cycle.
- R9: An accepted atomic launch holds bus_wait high until rsp_valid. In the rsp_valid cycle bus_wait is low and the read returns rsp_data.
- R10: Keys change only through key_we/key_idx/key_data and reset to 0.
- R11: A store with bus_addr[31:30]=00 gives a one-cycle fwd_valid in the next cycle, carrying the address and data. Shadow and window stores are never forwarded.
- R12: After reset all valid flags, err bits, fields, req_valid, fwd_valid and bus_wait are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Host access present, held while bus_wait is high |
| bus_we | input | 1 | 1 store, 0 load |
| bus_addr | input | 32 | Host physical address |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid when bus_wait is low |
| bus_wait | output | 1 | Stall for the current load |
| key_we | input | 1 | Privileged key write strobe |
| key_idx | input | 3 | Context whose key is written |
| key_data | input | 16 | New key |
| req_valid | output | 1 | Operation request pulse |
| req_ctx | output | 3 | Launching context |
| req_op | output | 2 | Opcode |
| req_raddr | output | 31 | Remote address argument |
| req_laddr | output | 31 | Local address argument |
| req_opa | output | 32 | Operand A |
| req_opb | output | 32 | Operand B |
| rsp_valid | input | 1 | Atomic result present |
| rsp_data | input | 32 | Fetched old value |
| fwd_valid | output | 1 | Plain remote store pulse |
| fwd_addr | output | 32 | Forwarded store address |
| fwd_data | output | 32 | Forwarded store data |

## Verification
A corrupted context field, flag or key shows up on the next window read of that context, and on the req_* outputs one cycle after the launch that uses it. A wrong accept or reject decision shows up in the same cycle as the launch read, through bus_rdata and bus_wait. It shows up one cycle later on req_valid, and it leaves the status field wrong on the next read. A launch controller stuck in its waiting state keeps bus_wait high past rsp_valid, so the stalled load never finishes.

// File: rtl/slaunch_pkg.sv
package slaunch_pkg;
    parameter int AW = 32;
    parameter int DW = 32;
    localparam int PAW = AW - 1;
    localparam int NFLAG = 5;

    typedef enum logic [1:0] {
        OP_SWAP = 2'd0,
        OP_FINC = 2'd1,
        OP_CAS  = 2'd2,
        OP_COPY = 2'd3
    } op_e;

    localparam logic [2:0] F_RADDR  = 3'd0;
    localparam logic [2:0] F_LADDR  = 3'd1;
    localparam logic [2:0] F_OPA    = 3'd2;
    localparam logic [2:0] F_OPB    = 3'd3;
    localparam logic [2:0] F_OPC    = 3'd4;
    localparam logic [2:0] F_STAT   = 3'd5;
    localparam logic [2:0] F_LAUNCH = 3'd7;

    localparam int V_RADDR = 0;
    localparam int V_LADDR = 1;
    localparam int V_OPA   = 2;
    localparam int V_OPB   = 3;
    localparam int V_OPC   = 4;

    typedef struct packed {
        logic [NFLAG-1:0] vld;
        op_e              opc;
        logic [PAW-1:0]   raddr;
        logic [PAW-1:0]   laddr;
        logic [DW-1:0]    opa;
        logic [DW-1:0]    opb;
    } args_t;

    typedef struct packed {
        logic  err;
        args_t a;
    } ctx_t;

    function automatic logic args_ready(args_t x);
        logic need;
        case (x.opc)
            OP_SWAP: need = x.vld[V_OPA];
            OP_FINC: need = 1'b1;
            OP_CAS:  need = x.vld[V_OPA] & x.vld[V_OPB];
            default: need = x.vld[V_LADDR];
        endcase
        return x.vld[V_RADDR] & x.vld[V_OPC] & need;
    endfunction
endpackage

// File: rtl/sl_decode.sv
module sl_decode (
    input  logic       bus_valid,
    input  logic       bus_we,
    input  logic [1:0] addr_top,
    input  logic [2:0] addr_field,
    output logic       shadow_wr,
    output logic       win_wr,
    output logic       win_rd,
    output logic       launch_rd,
    output logic       plain_wr
);
    import slaunch_pkg::*;

    always_comb begin
        shadow_wr = bus_valid & bus_we & addr_top[1];
        win_wr    = bus_valid & bus_we & (addr_top == 2'b01);
        win_rd    = bus_valid & ~bus_we & (addr_top == 2'b01);
        launch_rd = win_rd & (addr_field == F_LAUNCH);
        plain_wr  = bus_valid & bus_we & (addr_top == 2'b00);
    end
endmodule

// File: rtl/sl_ctx_bank.sv
module sl_ctx_bank #(
    parameter int NCTX  = 8,
    parameter int KEY_W = 16,
    localparam int CW   = $clog2(NCTX)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sh_wr,
    input  logic [CW-1:0]                 sh_ctx,
    input  logic                          sh_slot,
    input  logic [KEY_W-1:0]              sh_key,
    input  logic [slaunch_pkg::PAW-1:0]   sh_addr,
    input  logic                          win_wr,
    input  logic [CW-1:0]                 win_ctx,
    input  logic [2:0]                    win_field,
    input  logic [slaunch_pkg::DW-1:0]    win_data,
    input  logic                          key_we,
    input  logic [CW-1:0]                 key_idx,
    input  logic [KEY_W-1:0]              key_data,
    input  logic                          clr,
    input  logic                          set_err,
    input  logic [CW-1:0]                 act_ctx,
    output slaunch_pkg::ctx_t             rd_entry
);
    import slaunch_pkg::*;

    ctx_t ent [NCTX];

    for (genvar i = 0; i < NCTX; i++) begin : g_ctx
        typedef struct packed {
            ctx_t             e;
            logic [KEY_W-1:0] key;
        } slot_t;

        slot_t s_d, s_q;
        logic  hit_sh, hit_win, hit_act;

        always_comb begin
            hit_sh  = sh_wr && (sh_ctx == CW'(i));
            hit_win = win_wr && (win_ctx == CW'(i));
            hit_act = act_ctx == CW'(i);
            s_d = s_q;
            if (key_we && key_idx == CW'(i)) s_d.key = key_data;
            if (hit_sh && sh_key == s_q.key) begin
                if (sh_slot) begin
                    s_d.e.a.laddr        = sh_addr;
                    s_d.e.a.vld[V_LADDR] = 1'b1;
                end else begin
                    s_d.e.a.raddr        = sh_addr;
                    s_d.e.a.vld[V_RADDR] = 1'b1;
                end
            end
            if (hit_win) begin
                case (win_field)
                    F_OPA: begin
                        s_d.e.a.opa        = win_data;
                        s_d.e.a.vld[V_OPA] = 1'b1;
                    end
                    F_OPB: begin
                        s_d.e.a.opb        = win_data;
                        s_d.e.a.vld[V_OPB] = 1'b1;
                    end
                    F_OPC: begin
                        s_d.e.a.opc        = op_e'(win_data[1:0]);
                        s_d.e.a.vld[V_OPC] = 1'b1;
                    end
                    default: ;
                endcase
            end
            if (clr && hit_act) begin
                s_d.e.a.vld = '0;
                s_d.e.err   = 1'b0;
            end
            if (set_err && hit_act) s_d.e.err = 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        assign ent[i] = s_q.e;

        a_r2_bad_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (sh_wr && sh_ctx == CW'(i) && sh_key != s_q.key)
            |=> ($stable(s_q.e)));

        a_r5_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!(sh_wr && sh_ctx == CW'(i)) && !(win_wr && win_ctx == CW'(i))
             && !((clr || set_err) && act_ctx == CW'(i)))
            |=> $stable(s_q.e));

        a_r7_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && act_ctx == CW'(i)) |=> (s_q.e.a.vld == '0 && !s_q.e.err));
    end

    assign rd_entry = ent[act_ctx];
endmodule

// File: rtl/sl_launch_ctrl.sv
module sl_launch_ctrl #(
    parameter int NCTX = 8,
    localparam int CW  = $clog2(NCTX)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        launch_rd,
    input  logic [CW-1:0]               ctx_idx,
    input  slaunch_pkg::args_t          args,
    input  logic                        rsp_valid,
    input  logic [slaunch_pkg::DW-1:0]  rsp_data,
    output logic                        bus_wait,
    output logic [slaunch_pkg::DW-1:0]  launch_rdata,
    output logic                        clr,
    output logic                        set_err,
    output logic                        req_valid,
    output logic [CW-1:0]               req_ctx,
    output slaunch_pkg::args_t          req_args
);
    import slaunch_pkg::*;

    typedef enum logic {S_IDLE, S_WAIT} st_e;

    typedef struct packed {
        st_e           st;
        logic          rv;
        logic [CW-1:0] rctx;
        args_t         ra;
    } ctl_t;

    ctl_t c_d, c_q;
    logic ok;

    always_comb begin
        c_d          = c_q;
        c_d.rv       = 1'b0;
        clr          = 1'b0;
        set_err      = 1'b0;
        bus_wait     = 1'b0;
        launch_rdata = '0;
        ok           = args_ready(args);
        case (c_q.st)
            S_IDLE: begin
                if (launch_rd) begin
                    if (ok) begin
                        clr      = 1'b1;
                        c_d.rv   = 1'b1;
                        c_d.rctx = ctx_idx;
                        c_d.ra   = args;
                        if (args.opc != OP_COPY) begin
                            bus_wait = 1'b1;
                            c_d.st   = S_WAIT;
                        end
                    end else begin
                        set_err      = 1'b1;
                        launch_rdata = '1;
                    end
                end
            end
            default: begin
                bus_wait     = launch_rd & ~rsp_valid;
                launch_rdata = rsp_data;
                if (rsp_valid) c_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign req_valid = c_q.rv;
    assign req_ctx   = c_q.rctx;
    assign req_args  = c_q.ra;

    a_r7_req_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == S_IDLE && launch_rd && ok) |=> req_valid);

    a_r6_reject_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> !req_valid);

    a_r9_wait_until_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == S_WAIT && !rsp_valid) |=> (c_q.st == S_WAIT));
endmodule

// File: rtl/shadow_op_launcher.sv
module shadow_op_launcher #(
    parameter int NCTX  = 8,
    parameter int KEY_W = 16,
    localparam int CW   = $clog2(NCTX)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bus_valid,
    input  logic                                 bus_we,
    input  logic [slaunch_pkg::AW-1:0]           bus_addr,
    input  logic [slaunch_pkg::DW-1:0]           bus_wdata,
    output logic [slaunch_pkg::DW-1:0]           bus_rdata,
    output logic                                 bus_wait,
    input  logic                                 key_we,
    input  logic [CW-1:0]                        key_idx,
    input  logic [KEY_W-1:0]                     key_data,
    output logic                                 req_valid,
    output logic [CW-1:0]                        req_ctx,
    output logic [1:0]                           req_op,
    output logic [slaunch_pkg::PAW-1:0]          req_raddr,
    output logic [slaunch_pkg::PAW-1:0]          req_laddr,
    output logic [slaunch_pkg::DW-1:0]           req_opa,
    output logic [slaunch_pkg::DW-1:0]           req_opb,
    input  logic                                 rsp_valid,
    input  logic [slaunch_pkg::DW-1:0]           rsp_data,
    output logic                                 fwd_valid,
    output logic [slaunch_pkg::AW-1:0]           fwd_addr,
    output logic [slaunch_pkg::DW-1:0]           fwd_data
);
    import slaunch_pkg::*;

    localparam int CTX_LSB = 5;

    logic          shadow_wr, win_wr, win_rd, launch_rd, plain_wr;
    logic [2:0]    field;
    logic [CW-1:0] win_ctx;
    logic          clr, set_err;
    logic [DW-1:0] launch_rdata;
    ctx_t          entry;
    args_t         rq;

    assign field   = bus_addr[4:2];
    assign win_ctx = bus_addr[CTX_LSB +: CW];

    sl_decode u_dec (
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .addr_top  (bus_addr[AW-1:AW-2]),
        .addr_field(field),
        .shadow_wr (shadow_wr),
        .win_wr    (win_wr),
        .win_rd    (win_rd),
        .launch_rd (launch_rd),
        .plain_wr  (plain_wr)
    );

    sl_ctx_bank #(.NCTX(NCTX), .KEY_W(KEY_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sh_wr    (shadow_wr),
        .sh_ctx   (bus_wdata[DW-1 -: CW]),
        .sh_slot  (bus_wdata[KEY_W]),
        .sh_key   (bus_wdata[KEY_W-1:0]),
        .sh_addr  (bus_addr[PAW-1:0]),
        .win_wr   (win_wr),
        .win_ctx  (win_ctx),
        .win_field(field),
        .win_data (bus_wdata),
        .key_we   (key_we),
        .key_idx  (key_idx),
        .key_data (key_data),
        .clr      (clr),
        .set_err  (set_err),
        .act_ctx  (win_ctx),
        .rd_entry (entry)
    );

    sl_launch_ctrl #(.NCTX(NCTX)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_rd   (launch_rd),
        .ctx_idx     (win_ctx),
        .args        (entry.a),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .bus_wait    (bus_wait),
        .launch_rdata(launch_rdata),
        .clr         (clr),
        .set_err     (set_err),
        .req_valid   (req_valid),
        .req_ctx     (req_ctx),
        .req_args    (rq)
    );

    assign req_op    = rq.opc;
    assign req_raddr = rq.raddr;
    assign req_laddr = rq.laddr;
    assign req_opa   = rq.opa;
    assign req_opb   = rq.opb;

    always_comb begin
        bus_rdata = '0;
        if (launch_rd) begin
            bus_rdata = launch_rdata;
        end else if (win_rd) begin
            case (field)
                F_RADDR: bus_rdata = DW'(entry.a.raddr);
                F_LADDR: bus_rdata = DW'(entry.a.laddr);
                F_OPA:   bus_rdata = entry.a.opa;
                F_OPB:   bus_rdata = entry.a.opb;
                F_OPC:   bus_rdata = DW'(entry.a.opc);
                F_STAT:  bus_rdata = DW'({entry.err, entry.a.vld});
                default: bus_rdata = '0;
            endcase
        end
    end

    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } fwd_t;

    fwd_t f_d, f_q;

    always_comb begin
        f_d   = f_q;
        f_d.v = plain_wr;
        if (plain_wr) begin
            f_d.a = bus_addr;
            f_d.d = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign fwd_valid = f_q.v;
    assign fwd_addr  = f_q.a;
    assign fwd_data  = f_q.d;

    a_r11_fwd_plain_only: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(bus_valid && bus_we && bus_addr[AW-1:AW-2] == 2'b00));

    a_r9_wait_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> (bus_valid && !bus_we));
endmodule

// File: tb/sim_shadow_op_launcher.sv
module sim_shadow_op_launcher;
    localparam int PERIOD = 10;
    localparam int NCTX = 8;
    localparam int KW = 16;

    logic        clk = 0, rst_n = 0;
    logic        bus_valid = 0, bus_we = 0;
    logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
    logic        bus_wait;
    logic        key_we = 0;
    logic [2:0]  key_idx = 0;
    logic [15:0] key_data = 0;
    logic        req_valid;
    logic [2:0]  req_ctx;
    logic [1:0]  req_op;
    logic [30:0] req_raddr, req_laddr;
    logic [31:0] req_opa, req_opb;
    logic        rsp_valid = 0;
    logic [31:0] rsp_data = 0;
    logic        fwd_valid;
    logic [31:0] fwd_addr, fwd_data;

    shadow_op_launcher #(.NCTX(NCTX), .KEY_W(KW)) u0 (.*);

    always #(PERIOD/2) clk = ~clk;

    int nchk = 0, nerr = 0;
    int req_cnt = 0, fwd_cnt = 0;
    logic [2:0]  l_ctx;
    logic [1:0]  l_op;
    logic [30:0] l_raddr, l_laddr;
    logic [31:0] l_opa, l_opb, l_faddr, l_fdata;

    logic [30:0] m_raddr [NCTX];
    logic [30:0] m_laddr [NCTX];
    logic [31:0] m_opa [NCTX];
    logic [31:0] m_opb [NCTX];
    logic [1:0]  m_opc [NCTX];
    logic [4:0]  m_vld [NCTX];
    logic        m_err [NCTX];
    logic [15:0] m_key [NCTX];

    function automatic logic [31:0] resp_fn(logic [30:0] a);
        return {1'b0, a} ^ 32'h5A5A_1234;
    endfunction

    function automatic logic [31:0] win_a(int c, int f);
        return 32'h4000_0000 | (c << 5) | (f << 2);
    endfunction

    function automatic logic exp_ok(int c);
        logic need;
        case (m_opc[c])
            2'd0: need = m_vld[c][2];
            2'd1: need = 1'b1;
            2'd2: need = m_vld[c][2] & m_vld[c][3];
            default: need = m_vld[c][1];
        endcase
        return m_vld[c][0] & m_vld[c][4] & need;
    endfunction

    task automatic check(logic cond, string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!cond) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_we = 0;
    endtask

    task automatic bus_rd(logic [31:0] a, output logic [31:0] d, output int waits);
        @(negedge clk);
        bus_valid = 1; bus_we = 0; bus_addr = a;
        waits = 0;
        forever begin
            #1;
            if (!bus_wait) begin
                d = bus_rdata;
                break;
            end
            waits++;
            @(negedge clk);
        end
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic key_wr(int c, logic [15:0] k);
        @(negedge clk);
        key_we = 1; key_idx = 3'(c); key_data = k;
        @(negedge clk);
        key_we = 0;
        m_key[c] = k;
    endtask

    task automatic shadow_st(int c, logic slot, logic [30:0] pa, logic [15:0] k);
        int f0;
        f0 = fwd_cnt;
        bus_wr({1'b1, pa}, {3'(c), 12'd0, slot, k});
        @(negedge clk);
        if (k == m_key[c]) begin
            if (slot) begin m_laddr[c] = pa; m_vld[c][1] = 1; end
            else      begin m_raddr[c] = pa; m_vld[c][0] = 1; end
        end
        check(fwd_cnt == f0, "R11 shadow store forwarded", 32'(fwd_cnt), 32'(f0));
    endtask

    task automatic win_st(int c, int f, logic [31:0] d);
        int f0;
        f0 = fwd_cnt;
        bus_wr(win_a(c, f), d);
        @(negedge clk);
        case (f)
            2: begin m_opa[c] = d; m_vld[c][2] = 1; end
            3: begin m_opb[c] = d; m_vld[c][3] = 1; end
            4: begin m_opc[c] = d[1:0]; m_vld[c][4] = 1; end
            default: ;
        endcase
        check(fwd_cnt == f0, "R11 window store forwarded", 32'(fwd_cnt), 32'(f0));
    endtask

    task automatic check_ctx(int c, string tag);
        logic [31:0] d;
        int w;
        bus_rd(win_a(c, 0), d, w);
        check(d == {1'b0, m_raddr[c]}, {tag, " raddr"}, d, {1'b0, m_raddr[c]});
        bus_rd(win_a(c, 1), d, w);
        check(d == {1'b0, m_laddr[c]}, {tag, " laddr"}, d, {1'b0, m_laddr[c]});
        bus_rd(win_a(c, 2), d, w);
        check(d == m_opa[c], {tag, " opa"}, d, m_opa[c]);
        bus_rd(win_a(c, 3), d, w);
        check(d == m_opb[c], {tag, " opb"}, d, m_opb[c]);
        bus_rd(win_a(c, 4), d, w);
        check(d == {30'd0, m_opc[c]}, {tag, " opcode"}, d, {30'd0, m_opc[c]});
        bus_rd(win_a(c, 5), d, w);
        check(d == {26'd0, m_err[c], m_vld[c]}, {tag, " R4 status"}, d,
              {26'd0, m_err[c], m_vld[c]});
    endtask

    task automatic launch(int c);
        logic [31:0] d;
        int w, r0;
        logic ok;
        ok = exp_ok(c);
        r0 = req_cnt;
        bus_rd(win_a(c, 7), d, w);
        repeat (2) @(negedge clk);
        if (ok) begin
            check(req_cnt == r0 + 1, "R7 one request", 32'(req_cnt), 32'(r0 + 1));
            check(l_ctx == 3'(c) && l_op == m_opc[c] && l_raddr == m_raddr[c],
                  "R7 request ctx/op/raddr", {l_ctx, l_op, l_raddr[26:0]},
                  {3'(c), m_opc[c], m_raddr[c][26:0]});
            if (m_opc[c] == 2'd0 || m_opc[c] == 2'd2)
                check(l_opa == m_opa[c], "R7 request opa", l_opa, m_opa[c]);
            if (m_opc[c] == 2'd2)
                check(l_opb == m_opb[c], "R7 request opb", l_opb, m_opb[c]);
            if (m_opc[c] == 2'd3) begin
                check(l_laddr == m_laddr[c], "R7 request laddr", {1'b0, l_laddr}, {1'b0, m_laddr[c]});
                check(d == 0 && w == 0, "R8 copy returns 0 at once", d, 0);
            end else begin
                check(d == resp_fn(m_raddr[c]), "R9 atomic old value", d, resp_fn(m_raddr[c]));
                check(w >= 1, "R9 atomic waited", 32'(w), 1);
            end
            m_vld[c] = 0;
            m_err[c] = 0;
        end else begin
            check(d == 32'hFFFF_FFFF && w == 0, "R6 reject value", d, 32'hFFFF_FFFF);
            check(req_cnt == r0, "R6 no request", 32'(req_cnt), 32'(r0));
            m_err[c] = 1;
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (req_valid) begin
                req_cnt++;
                l_ctx = req_ctx; l_op = req_op; l_raddr = req_raddr;
                l_laddr = req_laddr; l_opa = req_opa; l_opb = req_opb;
            end
            if (fwd_valid) begin
                fwd_cnt++;
                l_faddr = fwd_addr; l_fdata = fwd_data;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (req_valid && req_op != 2'd3) begin
                logic [30:0] ra;
                int lat;
                ra = req_raddr;
                lat = $urandom_range(1, 4);
                repeat (lat) @(negedge clk);
                rsp_valid = 1; rsp_data = resp_fn(ra);
                @(negedge clk);
                rsp_valid = 0;
            end
        end
    end

    initial begin
        #(PERIOD * 200000);
        nerr++; nchk++;
        $display("FAIL watchdog expired act=%h exp=%h", 0, 1);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int w, f0;
        void'($urandom(32'd4711));
        for (int i = 0; i < NCTX; i++) begin
            m_raddr[i] = 0; m_laddr[i] = 0; m_opa[i] = 0; m_opb[i] = 0;
            m_opc[i] = 0; m_vld[i] = 0; m_err[i] = 0; m_key[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        check(!req_valid && !fwd_valid && !bus_wait, "R12 outputs idle after reset",
              {req_valid, fwd_valid, bus_wait}, 0);
        for (int c = 0; c < NCTX; c++) check_ctx(c, "R12 reset ctx");

        // R10 reset key is zero
        shadow_st(1, 0, 31'h1234_5678, 16'h0000);
        check_ctx(1, "R10 zero key accepted R1");
        for (int c = 0; c < NCTX; c++) key_wr(c, 16'(16'hA000 + c * 16'h111));

        // R1 both slots, R3 ignored writes to fields 0/1/5/7
        shadow_st(2, 0, 31'h0ABC_0010, m_key[2]);
        shadow_st(2, 1, 31'h7FFF_FFF0, m_key[2]);
        win_st(2, 0, 32'hDEAD_BEEF);
        win_st(2, 1, 32'hDEAD_BEEF);
        win_st(2, 5, 32'hFFFF_FFFF);
        win_st(2, 7, 32'hFFFF_FFFF);
        check_ctx(2, "R1 R3 slots and ignored writes");

        // R2 wrong key, R10 old key stops working after change
        shadow_st(2, 0, 31'h0000_0001, m_key[2] ^ 16'h0001);
        check_ctx(2, "R2 bad key");
        key_wr(3, 16'h5555);
        shadow_st(3, 0, 31'h0000_0777, 16'hA333);
        check_ctx(3, "R10 stale key rejected");

        // R6 reject: opcode set but remote address missing
        win_st(4, 4, 32'd1);
        launch(4);
        check_ctx(4, "R6 after reject");

        // R5 hold across long idle and other traffic
        win_st(2, 4, 32'd3);
        repeat (500) @(negedge clk);
        for (int k = 0; k < 20; k++) win_st(5, 2, $urandom);
        check_ctx(2, "R5 held");
        launch(2);
        check_ctx(2, "R7 flags cleared");

        // each opcode directed
        for (int op = 0; op < 4; op++) begin
            shadow_st(6, 0, 31'(32'h100 * (op + 1)), m_key[6]);
            shadow_st(6, 1, 31'(32'h55 + op), m_key[6]);
            win_st(6, 2, 32'h1111_0000 + op);
            win_st(6, 3, 32'h2222_0000 + op);
            win_st(6, 4, 32'(op));
            launch(6);
        end

        // R11 plain store forwarding
        f0 = fwd_cnt;
        bus_wr(32'h0000_1230, 32'hCAFE_0001);
        @(negedge clk);
        check(fwd_cnt == f0 + 1 && l_faddr == 32'h0000_1230 && l_fdata == 32'hCAFE_0001,
              "R11 plain store forwarded", l_fdata, 32'hCAFE_0001);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int c, act;
            c = $urandom_range(0, NCTX - 1);
            act = $urandom_range(0, 7);
            case (act)
                0, 1: shadow_st(c, 1'($urandom), 31'($urandom), m_key[c]);
                2: shadow_st(c, 1'($urandom), 31'($urandom),
                             m_key[c] ^ 16'($urandom_range(1, 65535)));
                3: win_st(c, $urandom_range(2, 4), $urandom);
                4: win_st(c, ($urandom_range(0, 3) == 3) ? 7 : $urandom_range(0, 1), $urandom);
                5: key_wr(c, 16'($urandom));
                6: launch(c);
                default: begin
                    logic [31:0] a, v;
                    a = {2'b00, 30'($urandom)};
                    v = $urandom;
                    f0 = fwd_cnt;
                    bus_wr(a, v);
                    @(negedge clk);
                    check(fwd_cnt == f0 + 1 && l_faddr == a && l_fdata == v,
                          "R11 random plain store", l_fdata, v);
                end
            endcase
            if (it % 25 == 0) check_ctx(c, "R3 random readback");
        end
        for (int c = 0; c < NCTX; c++) check_ctx(c, "R5 final");
        bus_rd(32'h0000_0040, d, w);
        check(d == 0 && w == 0, "R11 plain load returns 0", d, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule